// File: doc/BRIEF.md
# ECC Error Capture and Reporting Registers

This block sits beside a memory ECC checker and records its error events so that software can inspect them later. The checker sends a one-cycle pulse for each correctable (single-bit) error and for each uncorrectable (multi-bit) error. With each pulse it also sends the memory row number of the access. The block keeps a sticky flag for each of the two error kinds. Each flag stores the row of the first error of its kind, and that row stays frozen until software acknowledges the flag.

Two level outputs report the stored errors to the rest of the system. The first is an interrupt line that either error kind can drive. The second is a system-error line that only uncorrectable errors drive. A small command register gates both outputs. Software reads the status and command registers, and clears each flag, through a simple single-cycle register port. Reads are combinational on the address and writes take effect at the clock edge.

Top module: `ecap_status`

## Requirements
- R1: A single-error pulse while the single flag is clear sets that flag on the next clock edge and stores the row from that same cycle. Address 0 reads the flag in bit 0 and the row in bits 3:1.
- R2: A multi-error pulse while the multi flag is clear sets that flag on the next clock edge and stores the row from that same cycle. Address 1 reads the flag in bit 0 and the row in bits 3:1, kept apart from the single-error row.
- R3: While a flag is set and no clear arrives, later errors of the same kind change neither the flag nor its stored row.
- R4: A write to address 0 or 1 with data bit 0 set to 1 clears that flag. A write with bit 0 set to 0 leaves the flag unchanged. Writes never alter the stored row bits directly.
- R5: When an error pulse and a clear of the same flag arrive in one cycle, the error wins. The flag stays set and the row from that cycle is stored.
- R6: The two error kinds are independent. An error of one kind, or a clear of one flag, never changes the other flag or its row.
- R7: `serr_o` is high exactly while the multi flag is set and command bit 1 is 1.
- R8: `irq_o` is high exactly while one of two conditions holds: the single flag is set and command bit 0 is 1, or the multi flag is set and command bit 2 is 1.
- R9: The command register at address 2 holds bits 2:0 written by software and reads them back. Its other bits read 0, and address 3 reads 0.
- R10: A synchronous active-low reset clears both flags, both rows and the command register, so both outputs go low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_sgl_i | input | 1 | Correctable-error pulse from the checker |
| err_mul_i | input | 1 | Uncorrectable-error pulse from the checker |
| err_row_i | input | ROW_W | Memory row of the access that raised the pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Error interrupt level |
| serr_o | output | 1 | System-error level |

## Verification
The bench targets the cycle in which a clear and a new error of the same kind coincide. A design that gives the clear priority would drop that error and show an empty flag with a stale row. It also sends repeated errors with different rows against a set flag. A design without the lock would show the latest row instead of the first one. Further tests write zero to a flag register and fire one error kind while watching the other. These catch decoders that clear on any write and slots that share an enable. Random command values, checked every cycle, show whether each output is gated by the wrong command bit or latched instead of following its flag.

// File: rtl/ecap_pkg.sv
// Shared constants for the ECC error capture block.
// Assumes a 2-bit register address space and two error kinds.
package ecap_pkg;
    localparam int ROW_W_DEF  = 3;
    localparam int DATA_W_DEF = 8;
    localparam int ADDR_W     = 2;
    localparam int CMD_W      = 3;
    localparam int NKIND      = 2;
    localparam int KIND_SGL   = 0;
    localparam int KIND_MUL   = 1;

    localparam logic [ADDR_W-1:0] A_SGL = 2'd0;
    localparam logic [ADDR_W-1:0] A_MUL = 2'd1;
    localparam logic [ADDR_W-1:0] A_CMD = 2'd2;

    localparam int CMD_SGL_IRQ  = 0;
    localparam int CMD_MUL_SERR = 1;
    localparam int CMD_MUL_IRQ  = 2;
    localparam int FLAG_BIT     = 0;
endpackage

// File: rtl/ecap_slot.sv
// One sticky capture slot: a flag plus the row of the first event.
// Assumes evt_i is a single-cycle pulse and clr_i a decoded write-1-to-clear.
// A new event in the same cycle as a clear wins and is captured.
module ecap_slot #(
    parameter int ROW_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic             clr_i,
    output logic             flag_o,
    output logic [ROW_W-1:0] row_o
);
    logic             flag_q;
    logic [ROW_W-1:0] row_q;
    logic             armed;

    // Capture is open when the flag is clear or being cleared this cycle.
    assign armed = !flag_q || clr_i;

    // Flag and row update: capture first event, then hold until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            row_q  <= '0;
        end else if (evt_i && armed) begin
            flag_q <= 1'b1;
            row_q  <= row_i;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
    assign row_o  = row_q;
endmodule

// File: rtl/ecap_regif.sv
// Register port: decodes flag clears, holds the command register,
// and drives combinational read data. Assumes ROW_W+1 <= DATA_W and CMD_W <= DATA_W.
module ecap_regif
    import ecap_pkg::*;
#(
    parameter int ROW_W  = 3,
    parameter int DATA_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [DATA_W-1:0]           wdata_i,
    input  logic [NKIND-1:0]            flag_i,
    input  logic [NKIND-1:0][ROW_W-1:0] row_i,
    output logic [NKIND-1:0]            clr_o,
    output logic [CMD_W-1:0]            cmd_o,
    output logic [DATA_W-1:0]           rdata_o
);
    logic [CMD_W-1:0] cmd_q;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^wdata_i[DATA_W-1:CMD_W];

    // Write-1-to-clear decode for each status register.
    always_comb begin
        clr_o           = '0;
        clr_o[KIND_SGL] = wr_i && (addr_i == A_SGL) && wdata_i[FLAG_BIT];
        clr_o[KIND_MUL] = wr_i && (addr_i == A_MUL) && wdata_i[FLAG_BIT];
    end

    // Command register: software-written enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (wr_i && (addr_i == A_CMD)) begin
            cmd_q <= wdata_i[CMD_W-1:0];
        end
    end

    // Read mux: status layout is flag at bit 0, row above it.
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_SGL: begin
                rdata_o[FLAG_BIT]  = flag_i[KIND_SGL];
                rdata_o[ROW_W:1]   = row_i[KIND_SGL];
            end
            A_MUL: begin
                rdata_o[FLAG_BIT]  = flag_i[KIND_MUL];
                rdata_o[ROW_W:1]   = row_i[KIND_MUL];
            end
            A_CMD:   rdata_o[CMD_W-1:0] = cmd_q;
            default: rdata_o = '0;
        endcase
    end

    assign cmd_o = cmd_q;
endmodule

// File: rtl/ecap_report.sv
// Output gating: combines flags with command enables into level outputs.
// Assumes flags come straight from registers, so outputs are glitch-free.
module ecap_report
    import ecap_pkg::*;
(
    input  logic [NKIND-1:0] flag_i,
    input  logic [CMD_W-1:0] cmd_i,
    output logic             irq_o,
    output logic             serr_o
);
    // Interrupt: either kind, each with its own enable.
    always_comb begin
        irq_o = (flag_i[KIND_SGL] && cmd_i[CMD_SGL_IRQ]) ||
                (flag_i[KIND_MUL] && cmd_i[CMD_MUL_IRQ]);
    end

    // System error: uncorrectable errors only.
    always_comb begin
        serr_o = flag_i[KIND_MUL] && cmd_i[CMD_MUL_SERR];
    end
endmodule

// File: rtl/ecap_status.sv
// Top of the ECC error capture block: two sticky capture slots,
// a register port and gated report outputs. Synchronous active-low reset.
module ecap_status
    import ecap_pkg::*;
#(
    parameter int ROW_W  = ROW_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_sgl_i,
    input  logic              err_mul_i,
    input  logic [ROW_W-1:0]  err_row_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o,
    output logic              serr_o
);
    logic [NKIND-1:0]            evt;
    logic [NKIND-1:0]            clr;
    logic [NKIND-1:0]            flag;
    logic [NKIND-1:0][ROW_W-1:0] row;
    logic [CMD_W-1:0]            cmd_q;

    logic             sgl_flag, mul_flag, clr_sgl, clr_mul;
    logic [ROW_W-1:0] sgl_row, mul_row;

    assign evt[KIND_SGL] = err_sgl_i;
    assign evt[KIND_MUL] = err_mul_i;

    // One capture slot per error kind.
    for (genvar k = 0; k < NKIND; k++) begin : g_slot
        ecap_slot #(.ROW_W(ROW_W)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt_i  (evt[k]),
            .row_i  (err_row_i),
            .clr_i  (clr[k]),
            .flag_o (flag[k]),
            .row_o  (row[k])
        );
    end

    ecap_regif #(.ROW_W(ROW_W), .DATA_W(DATA_W)) u_regif (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .flag_i  (flag),
        .row_i   (row),
        .clr_o   (clr),
        .cmd_o   (cmd_q),
        .rdata_o (reg_rdata_o)
    );

    ecap_report u_report (
        .flag_i (flag),
        .cmd_i  (cmd_q),
        .irq_o  (irq_o),
        .serr_o (serr_o)
    );

    // Named views of each slot for the bound checker.
    assign sgl_flag = flag[KIND_SGL];
    assign mul_flag = flag[KIND_MUL];
    assign sgl_row  = row[KIND_SGL];
    assign mul_row  = row[KIND_MUL];
    assign clr_sgl  = clr[KIND_SGL];
    assign clr_mul  = clr[KIND_MUL];
endmodule

// File: rtl/ecap_status_chk.sv
// Checker for ecap_status: capture, lock, clear priority and output gating.
module ecap_status_chk
    import ecap_pkg::*;
#(
    parameter int ROW_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             err_sgl_i,
    input logic             err_mul_i,
    input logic [ROW_W-1:0] err_row_i,
    input logic             sgl_flag,
    input logic             mul_flag,
    input logic [ROW_W-1:0] sgl_row,
    input logic [ROW_W-1:0] mul_row,
    input logic             clr_sgl,
    input logic             clr_mul,
    input logic [CMD_W-1:0] cmd_q,
    input logic             irq_o,
    input logic             serr_o
);
    AST_SGL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        err_sgl_i && !sgl_flag |=> sgl_flag && sgl_row == $past(err_row_i)); // R1
    AST_MUL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        err_mul_i && !mul_flag |=> mul_flag && mul_row == $past(err_row_i)); // R2
    AST_SGL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        sgl_flag && !clr_sgl |=> sgl_flag && $stable(sgl_row)); // R3
    AST_MUL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        mul_flag && !clr_mul |=> mul_flag && $stable(mul_row)); // R3
    AST_SGL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_sgl && !err_sgl_i |=> !sgl_flag); // R4
    AST_MUL_RACE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_mul && err_mul_i |=> mul_flag && mul_row == $past(err_row_i)); // R5
    AST_KIND_INDEP: assert property (@(posedge clk) disable iff (!rst_n)
        !mul_flag && !err_mul_i |=> !mul_flag); // R6
    AST_SERR_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        serr_o |-> mul_flag && cmd_q[CMD_MUL_SERR]); // R7
    AST_SERR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mul_flag) |-> !serr_o); // R7
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !sgl_flag && !mul_flag |-> !irq_o); // R8
endmodule

bind ecap_status ecap_status_chk #(.ROW_W(ROW_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_sgl_i (err_sgl_i),
    .err_mul_i (err_mul_i),
    .err_row_i (err_row_i),
    .sgl_flag  (sgl_flag),
    .mul_flag  (mul_flag),
    .sgl_row   (sgl_row),
    .mul_row   (mul_row),
    .clr_sgl   (clr_sgl),
    .clr_mul   (clr_mul),
    .cmd_q     (cmd_q),
    .irq_o     (irq_o),
    .serr_o    (serr_o)
);

// File: tb/ecap_status_tb.sv
// Bench for ecap_status: behavioural reference model compared every cycle.
module ecap_status_tb;
    localparam int ROW_W  = 3;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              err_sgl_i = 1'b0;
    logic              err_mul_i = 1'b0;
    logic [ROW_W-1:0]  err_row_i = '0;
    logic              reg_wr_i = 1'b0;
    logic [1:0]        reg_addr_i = '0;
    logic [DATA_W-1:0] reg_wdata_i = '0;
    logic [DATA_W-1:0] reg_rdata_o;
    logic              irq_o, serr_o;

    int n_cmp = 0;
    int n_bad = 0;
    string phase = "R10";

    // Reference model state.
    bit     m_sf, m_mf;
    int     m_sr, m_mr, m_cmd;

    always #2.5 clk = ~clk;

    ecap_status #(.ROW_W(ROW_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .err_sgl_i(err_sgl_i), .err_mul_i(err_mul_i), .err_row_i(err_row_i),
        .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .irq_o(irq_o), .serr_o(serr_o)
    );

    // Reference model: updates from the inputs present at each rising edge.
    always @(posedge clk) begin
        bit cs, cm;
        if (!rst_n) begin
            m_sf = 0; m_mf = 0; m_sr = 0; m_mr = 0; m_cmd = 0;
        end else begin
            cs = reg_wr_i && reg_addr_i == 0 && reg_wdata_i[0];
            cm = reg_wr_i && reg_addr_i == 1 && reg_wdata_i[0];
            if (err_sgl_i && (!m_sf || cs)) begin m_sf = 1; m_sr = err_row_i; end
            else if (cs) m_sf = 0;
            if (err_mul_i && (!m_mf || cm)) begin m_mf = 1; m_mr = err_row_i; end
            else if (cm) m_mf = 0;
            if (reg_wr_i && reg_addr_i == 2) m_cmd = reg_wdata_i & 8'h07;
        end
    end

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare all outputs against the model; tags name the requirement under test.
    task automatic compare();
        int exp_rd;
        case (reg_addr_i)
            2'd0:    exp_rd = (m_sr << 1) | m_sf;
            2'd1:    exp_rd = (m_mr << 1) | m_mf;
            2'd2:    exp_rd = m_cmd;
            default: exp_rd = 0;
        endcase
        check({phase, "/rdata"}, reg_rdata_o, exp_rd);
        check({phase, "/R8 irq"}, irq_o,
              int'((m_sf && m_cmd[0]) || (m_mf && m_cmd[2])));
        check({phase, "/R7 serr"}, serr_o, int'(m_mf && m_cmd[1]));
    endtask

    // One cycle: check outputs away from the edge, then drive the next inputs.
    task automatic step(bit s, bit m, int row, bit wr, int addr, int wd);
        @(negedge clk);
        if (rst_n) compare();
        err_sgl_i   = s;
        err_mul_i   = m;
        err_row_i   = ROW_W'(row);
        reg_wr_i    = wr;
        reg_addr_i  = 2'(addr);
        reg_wdata_i = DATA_W'(wd);
    endtask

    task automatic idle(int addr);
        step(0, 0, 0, 0, addr, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: reset values on every register and output.
        phase = "R10";
        for (int a = 0; a < 4; a++) idle(a);

        // R9: command register read-back, upper bits masked, address 3 empty.
        phase = "R9";
        step(0, 0, 0, 1, 2, 8'hFF);
        idle(2); idle(3);
        step(0, 0, 0, 1, 2, 8'h00);
        idle(2);

        // R1: single error captured, then enable interrupt.
        phase = "R1";
        step(1, 0, 5, 0, 0, 0);
        idle(0);
        step(0, 0, 0, 1, 2, 8'h01);
        idle(0);

        // R3: later single errors with other rows are ignored.
        phase = "R3";
        step(1, 0, 2, 0, 0, 0);
        step(1, 0, 7, 0, 0, 0);
        idle(0);

        // R4: writing 0 keeps the flag; writing 1 clears it.
        phase = "R4";
        step(0, 0, 0, 1, 0, 8'hFE);
        idle(0);
        step(0, 0, 0, 1, 0, 8'h01);
        idle(0);

        // R2 and R7: multi error with system-error enable.
        phase = "R2";
        step(0, 1, 6, 0, 1, 0);
        idle(1);
        phase = "R7";
        step(0, 0, 0, 1, 2, 8'h02);
        idle(1); idle(0);

        // R6: multi error leaves the single slot alone; clearing single leaves multi.
        phase = "R6";
        step(0, 1, 1, 1, 0, 8'h01);
        idle(0); idle(1);

        // R5: clear and new error in the same cycle, error wins.
        phase = "R5";
        step(0, 1, 3, 1, 1, 8'h01);
        idle(1);
        step(1, 0, 4, 0, 0, 0);
        step(1, 0, 2, 1, 0, 8'h01);
        idle(0);

        // R8: multi error routed to the interrupt by its own enable.
        phase = "R8";
        step(0, 0, 0, 1, 2, 8'h04);
        idle(1); idle(0);

        // Random traffic across all requirements.
        phase = "R1-R9 random";
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 4) == 0, ($urandom % 5) == 0, int'($urandom % 8),
                 ($urandom % 3) == 0, int'($urandom % 4), int'($urandom % 256));
        end
        idle(0);

        // R10: reset in the middle of activity returns all state to zero.
        phase = "R10";
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int a = 0; a < 4; a++) idle(a);
        idle(0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule